// File: doc/BRIEF.md
# Multiplexed-Bus Machine Cycle Controller

This block carries out one bus transaction at a time for a small 8-bit processor core with 16-bit addresses. The core names the kind of transfer: opcode fetch, memory read, memory write, port read or port write. It also supplies an address and, for writes, a data byte. The controller then plays the matching sequence of clock states on an external bus and returns the fetched or read byte together with a single-cycle completion pulse.

The external bus shares eight lines between the low address byte and the data byte. In the first state of each transfer the controller puts the low address on the shared lines and raises an address-latch strobe, so an external latch can hold that byte. After that, the same lines carry data. The high address byte has lines of its own. Active-low read and write strobes, a memory/port status line and a two-bit cycle-kind status tell the outside world what is happening. A slow device can stretch the transfer by holding the ready input low.

Top module: `busCycleCtl`

## Requirements
- R1: While reset is held and after it is released, with no request made, rdN and wrN are 1, ale is 0, adOe is 0, {s1,s0} is 00, ioM is 0 and cycleDone is 0.
- R2: A request is taken only while the controller is idle and only when reqKind is one of the five valid codes (0 fetch, 1 memory read, 2 memory write, 3 port read, 4 port write). A reqValid pulse while a transfer is running, or with codes 5 to 7, starts no transfer: ale and the strobes stay inactive.
- R3: The first state after a request is taken drives ale high for exactly one clock, with adOe high, adOut equal to address bits 7:0, and rdN and wrN both high. addrHi carries address bits 15:8 for memory kinds. For port kinds it repeats the 8-bit port number (address bits 7:0), so the effective address is {port, port}.
- R4: For the whole transfer, ioM is 1 for port kinds and 0 for memory kinds, and {s1,s0} is 11 for a fetch, 10 for either read, and 01 for either write. In the idle cycle, including the cycle that carries cycleDone, {s1,s0} is 00.
- R5: rdN goes low only for fetch and read kinds, and wrN only for write kinds. The two are never low together. A strobe falls only in the clock right after the ale clock.
- R6: ready is sampled at the end of the second state and at the end of each wait state. Each low sample adds one wait state with the strobe held, so a strobe stays low for 2 + N clocks when N low samples occur.
- R7: For fetch and read kinds, rdData holds the byte seen on adIn at the last clock edge before rdN returns high. It is valid from the cycle that carries cycleDone.
- R8: Outside the ale clock, adOe is high only while wrN is low, and there adOut equals the request's write byte. adOe is never high while rdN is low.
- R9: A memory read, memory write or port transfer takes 3 + N states, and a fetch takes 4 + N. cycleDone is high for exactly one clock, the clock right after the last state. Counted from the accepting clock edge, it is visible after 4 + N edges (5 + N for a fetch).
- R10: A request presented in the same cycle as cycleDone is accepted, and its ale clock follows immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core asks for a transfer this cycle |
| reqKind | input | 3 | Transfer kind code (0..4 valid) |
| reqAddr | input | 16 | Memory address, or port number in bits 7:0 |
| reqWdata | input | 8 | Byte to write |
| rdData | output | 8 | Byte returned by the last fetch or read |
| cycleDone | output | 1 | One-clock completion pulse |
| addrHi | output | 8 | High address lines |
| adOut | output | 8 | Shared lines, driven value |
| adOe | output | 1 | Output enable of the shared lines |
| adIn | input | 8 | Shared lines, received value |
| ale | output | 1 | Low-address latch strobe, active high |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| ioM | output | 1 | 1 for port transfers, 0 for memory |
| s1 | output | 1 | Cycle-kind status, upper bit |
| s0 | output | 1 | Cycle-kind status, lower bit |
| ready | input | 1 | Device ready; low stretches the transfer |

## Verification
The bench attaches a device model with a programmable number of wait states. It confirms that each transfer stretches by exactly that count. A controller that sampled ready one state late, or let the strobe go early, would show a wrong strobe length or capture the idle filler byte instead of the addressed data. The model latches the low address on ale and rebuilds the full address from that latch. A controller that put data on the shared lines during ale, or repeated the wrong byte on the high lines for port kinds, would therefore hit the wrong location. Directed cases cover back-to-back requests in the completion cycle, requests made mid-transfer or with unused codes (a controller that took them would start a spurious ale), and overlap of bus drive with the read strobe.

// File: rtl/busCyclePkg.sv
package busCyclePkg;

  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_MEMRD = 3'd1,
    CYC_MEMWR = 3'd2,
    CYC_IORD  = 3'd3,
    CYC_IOWR  = 3'd4
  } cycKind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_TW,
    ST_T3,
    ST_T4
  } busState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;       // take the request fields
    logic addrPhase;  // first state: address on shared lines
    logic xferPhase;  // strobe states (T2, waits, T3)
    logic capture;    // store the read byte
    logic active;     // a transfer is in progress
  } busStrobe_t;

  function automatic logic kindValid(input logic [2:0] k);
    return k <= CYC_IOWR;
  endfunction

  function automatic logic kindRead(input logic [2:0] k);
    return (k == CYC_FETCH) || (k == CYC_MEMRD) || (k == CYC_IORD);
  endfunction

  function automatic logic kindWrite(input logic [2:0] k);
    return (k == CYC_MEMWR) || (k == CYC_IOWR);
  endfunction

  function automatic logic kindIo(input logic [2:0] k);
    return (k == CYC_IORD) || (k == CYC_IOWR);
  endfunction

endpackage

// File: rtl/busCycleFsm.sv
module busCycleFsm
  import busCyclePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  input  logic       ready,
  output busStrobe_t strb,
  output logic       cycleDone
);

  busState_e state, stateNext;
  logic      fetchQ;
  logic      take;

  assign take = (state == ST_IDLE) && reqValid && kindValid(reqKind);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (take) stateNext = ST_T1;
      ST_T1:   stateNext = ST_T2;
      ST_T2,
      ST_TW:   stateNext = ready ? ST_T3 : ST_TW;
      ST_T3:   stateNext = fetchQ ? ST_T4 : ST_IDLE;
      ST_T4:   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      fetchQ    <= 1'b0;
      cycleDone <= 1'b0;
    end else begin
      state     <= stateNext;
      cycleDone <= ((state == ST_T3) && !fetchQ) || (state == ST_T4);
      if (take) fetchQ <= (reqKind == CYC_FETCH);
    end
  end

  always_comb begin
    strb.load      = take;
    strb.addrPhase = (state == ST_T1);
    strb.xferPhase = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
    strb.capture   = (state == ST_T3);
    strb.active    = (state != ST_IDLE);
  end

endmodule

// File: rtl/busCycleDpath.sv
module busCycleDpath
  import busCyclePkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  busStrobe_t               strb,
  input  logic [2:0]               reqKind,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W-1:0]        adIn,
  output logic [DATA_W-1:0]        rdData,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     ioM,
  output logic                     s1,
  output logic                     s0
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [2:0]        kindQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              isRd, isWr, isIo, isFetch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ  <= CYC_FETCH;
      addrQ  <= '0;
      wdataQ <= '0;
      rdData <= '0;
    end else begin
      if (strb.load) begin
        kindQ  <= reqKind;
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.capture && isRd) rdData <= adIn;
    end
  end

  assign isRd    = kindRead(kindQ);
  assign isWr    = kindWrite(kindQ);
  assign isIo    = kindIo(kindQ);
  assign isFetch = (kindQ == CYC_FETCH);

  // port kinds repeat the port number on the high lines
  assign addrHi = isIo ? HI_W'(addrQ[DATA_W-1:0]) : addrQ[ADDR_W-1:DATA_W];
  assign adOut  = strb.addrPhase ? addrQ[DATA_W-1:0] : wdataQ;
  assign adOe   = strb.addrPhase || (strb.xferPhase && isWr);
  assign ale    = strb.addrPhase;
  assign rdN    = !(strb.xferPhase && isRd);
  assign wrN    = !(strb.xferPhase && isWr);
  assign ioM    = strb.active && isIo;
  assign s1     = strb.active && (isFetch || isRd);
  assign s0     = strb.active && (isFetch || isWr);

endmodule

// File: rtl/busCycleCtl.sv
module busCycleCtl
  import busCyclePkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [2:0]               reqKind,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  output logic [DATA_W-1:0]        rdData,
  output logic                     cycleDone,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  input  logic [DATA_W-1:0]        adIn,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     ioM,
  output logic                     s1,
  output logic                     s0,
  input  logic                     ready
);

  busStrobe_t strb;

  busCycleFsm uFsm (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqKind   (reqKind),
    .ready     (ready),
    .strb      (strb),
    .cycleDone (cycleDone)
  );

  busCycleDpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqKind  (reqKind),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .adIn     (adIn),
    .rdData   (rdData),
    .addrHi   (addrHi),
    .adOut    (adOut),
    .adOe     (adOe),
    .ale      (ale),
    .rdN      (rdN),
    .wrN      (wrN),
    .ioM      (ioM),
    .s1       (s1),
    .s0       (s0)
  );

endmodule

// File: rtl/busCycleChk.sv
module busCycleChk (
  input logic clk,
  input logic rstN,
  input logic ale,
  input logic rdN,
  input logic wrN,
  input logic adOe,
  input logic ready,
  input logic cycleDone,
  input logic s1,
  input logic s0
);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  // R8
  bus_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(adOe && !rdN));

  // R3
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN && adOe));

  // R3
  ale_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  // R5
  rd_after_ale_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> $past(ale));

  // R5
  wr_after_ale_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrN) |-> $past(ale));

  // R6
  wait_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdN) |-> $past(ready, 2));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);

  // R4
  idle_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> (!s1 && !s0 && rdN && wrN));

endmodule

bind busCycleCtl busCycleChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ale       (ale),
  .rdN       (rdN),
  .wrN       (wrN),
  .adOe      (adOe),
  .ready     (ready),
  .cycleDone (cycleDone),
  .s1        (s1),
  .s0        (s0)
);

// File: tb/sim_busCycleCtl.sv
module sim_busCycleCtl;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {kind[3], addr[16], wdata[8], waits[4]}
  localparam logic [30:0] VEC [NVEC] = '{
    {3'd0, 16'h3A7C, 8'h00, 4'd0},
    {3'd1, 16'h2050, 8'h00, 4'd2},
    {3'd2, 16'h3050, 8'hA5, 4'd1},
    {3'd3, 16'h1F44, 8'h00, 4'd0},
    {3'd4, 16'hBE09, 8'h3C, 4'd3},
    {3'd0, 16'hFFFF, 8'h00, 4'd4},
    {3'd2, 16'h0000, 8'hFF, 4'd0},
    {3'd1, 16'h8001, 8'h00, 4'd7}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = 3'd0;
  logic [15:0] reqAddr = 16'h0;
  logic [7:0]  reqWdata = 8'h0;
  logic [7:0]  rdData, addrHi, adOut, adIn;
  logic        cycleDone, adOe, ale, rdN, wrN, ioM, s1, s0, ready;

  int          nChecks = 0;
  int          nFail = 0;
  int          waitN = 0;
  int          strobeCnt = 0;
  logic [7:0]  latchLo = 8'h0;
  logic [15:0] lastWrAddr = 16'h0;
  logic [7:0]  lastWrData = 8'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busCycleCtl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdData(rdData),
    .cycleDone(cycleDone), .addrHi(addrHi), .adOut(adOut), .adOe(adOe),
    .adIn(adIn), .ale(ale), .rdN(rdN), .wrN(wrN), .ioM(ioM),
    .s1(s1), .s0(s0), .ready(ready)
  );

  function automatic logic [7:0] devByte(input logic [15:0] a, input logic io);
    return a[15:8] ^ a[7:0] ^ (io ? 8'hC3 : 8'h3C) ^ 8'h11;
  endfunction

  // device model: address latch, wait-state counter, read source, write sink
  always @(posedge clk) begin
    if (ale) latchLo <= adOut;
    strobeCnt <= (!rdN || !wrN) ? strobeCnt + 1 : 0;
    if (!wrN) begin
      lastWrAddr <= {addrHi, latchLo};
      lastWrData <= adOut;
    end
  end
  assign ready = (strobeCnt >= waitN);
  assign adIn  = !rdN ? devByte({addrHi, latchLo}, ioM) : 8'hEE;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  task automatic runVec(input logic [2:0] k, input logic [15:0] a,
                        input logic [7:0] wd, input int w);
    bit fK, rdK, wrK, ioK, dirBad, wrBad, sawRd, sawWr, sBad;
    logic [7:0] expHi, expLo, expRd;
    logic [1:0] expS;
    int edges, aleCnt, strbCnt;
    fK  = (k == 3'd0);
    rdK = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
    wrK = (k == 3'd2) || (k == 3'd4);
    ioK = (k == 3'd3) || (k == 3'd4);
    expLo = a[7:0];
    expHi = ioK ? a[7:0] : a[15:8];
    expRd = devByte({expHi, expLo}, ioK);
    expS  = {fK | rdK, fK | wrK};
    waitN = w;
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    edges = 1;
    check(ale == 1'b1 && adOe == 1'b1, "R3 ale/oe in first state", {ale, adOe}, 2'b11);
    check(adOut == expLo, "R3 low address on shared lines", adOut, expLo);
    check(addrHi == expHi, "R3 high lines", addrHi, expHi);
    check(ioM == ioK, "R4 ioM", ioM, ioK);
    aleCnt = 0; strbCnt = 0; dirBad = 0; wrBad = 0; sawRd = 0; sawWr = 0; sBad = 0;
    while (!cycleDone && edges < 40) begin
      if (ale) aleCnt++;
      if (!rdN) sawRd = 1;
      if (!wrN) sawWr = 1;
      if (!rdN || !wrN) strbCnt++;
      if (adOe && !rdN) dirBad = 1;
      if (!ale && adOe && wrN) dirBad = 1;
      if (!wrN && (!adOe || adOut !== wd)) wrBad = 1;
      if ({s1, s0} !== expS || ioM !== ioK) sBad = 1;
      @(negedge clk);
      edges++;
    end
    check(edges == 4 + w + int'(fK), "R9 latency to done", edges, 4 + w + int'(fK));
    check(strbCnt == 2 + w, "R6 strobe length with waits", strbCnt, 2 + w);
    check(aleCnt == 1, "R3 single ale clock", aleCnt, 1);
    check(sawRd == rdK && sawWr == wrK, "R5 strobe kind", {sawRd, sawWr}, {rdK, wrK});
    check(!sBad, "R4 status held", {s1, s0}, expS);
    check(!dirBad, "R8 bus direction", dirBad, 0);
    check({s1, s0} == 2'b00, "R4 idle status at done", {s1, s0}, 0);
    if (wrK) begin
      check(!wrBad, "R8 write data while wrN low", wrBad, 0);
      check(lastWrAddr == {expHi, expLo} && lastWrData == wd, "R8 written byte",
            {lastWrAddr, lastWrData}, {expHi, expLo, wd});
    end
    if (rdK) check(rdData == expRd, "R7 read data", rdData, expRd);
    @(negedge clk);
    check(cycleDone == 1'b0, "R9 done one clock", cycleDone, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(rdN && wrN && !ale && !adOe && {s1, s0} == 2'b00 && !ioM && !cycleDone,
          "R1 reset state", {rdN, wrN, ale, adOe, s1, s0, ioM, cycleDone}, 8'b1100_0000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(rdN && wrN && !ale && !adOe && {s1, s0} == 2'b00 && !ioM && !cycleDone,
          "R1 after reset release", {rdN, wrN, ale, adOe, s1, s0, ioM, cycleDone}, 8'b1100_0000);

    for (int i = 0; i < NVEC; i++) begin
      runVec(VEC[i][30:28], VEC[i][27:12], VEC[i][11:4], int'(VEC[i][3:0]));
    end

    // R10 back-to-back: new request in the done cycle
    waitN = 0;
    @(negedge clk);
    reqValid = 1'b1; reqKind = 3'd1; reqAddr = 16'h5566;
    @(negedge clk);
    reqValid = 1'b0;
    for (int e = 0; e < 10 && !cycleDone; e++) @(negedge clk);
    reqValid = 1'b1; reqKind = 3'd2; reqAddr = 16'h4411; reqWdata = 8'h77;
    @(negedge clk);
    reqValid = 1'b0;
    check(ale == 1'b1 && adOut == 8'h11, "R10 ale right after done", {ale, adOut}, {1'b1, 8'h11});
    for (int e = 0; e < 10 && !cycleDone; e++) @(negedge clk);
    check(lastWrData == 8'h77 && lastWrAddr == 16'h4411, "R10 second transfer data",
          {lastWrAddr, lastWrData}, {16'h4411, 8'h77});

    // R2 requests while busy are ignored
    waitN = 3;
    @(negedge clk);
    reqValid = 1'b1; reqKind = 3'd1; reqAddr = 16'h1234;
    @(negedge clk);
    reqKind = 3'd0; reqAddr = 16'hAAAA;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    for (int e = 0; e < 20 && !cycleDone; e++) @(negedge clk);
    check(rdData == devByte(16'h1234, 1'b0), "R2 busy request did not disturb",
          rdData, devByte(16'h1234, 1'b0));
    begin
      bit spur;
      spur = 0;
      for (int e = 0; e < 4; e++) begin
        @(negedge clk);
        if (ale || !rdN || !wrN || s1 || s0) spur = 1;
      end
      check(!spur, "R2 no transfer from busy request", spur, 0);
    end

    // R2 unused kind codes
    for (int c = 5; c < 8; c++) begin
      bit spur;
      spur = 0;
      @(negedge clk);
      reqValid = 1'b1; reqKind = 3'(c); reqAddr = 16'h0F0F;
      @(negedge clk);
      reqValid = 1'b0;
      for (int e = 0; e < 4; e++) begin
        if (ale || !rdN || !wrN || s1 || s0 || adOe) spur = 1;
        @(negedge clk);
      end
      check(!spur, "R2 unused kind code ignored", c, 0);
    end

    finishRun();
  end

endmodule